// File: doc/BRIEF.md
# Double-Buffered Multi-Channel DAC Register Controller

This block carries out the commands that a serial frame receiver has already decoded, for a bank of DAC channels (eight by default). Every channel keeps two registers. A holding register accepts new codes. An active register drives the converter code seen at the outputs. Each channel also has an enable flag. A single reference selector chooses between the on-chip and the external reference, and a separate flag records whether the on-chip reference is powered.

The receiver presents a 4-bit command, a 4-bit address and a data code, then pulses `exec_i` for one clock. The controller changes its state on that clock edge, so the outputs show the result one cycle after the strobe. Two parameters set the power-on state. One chooses a zero-scale or mid-scale starting code. The other chooses whether the block starts on the on-chip reference or the external one. Software can write holding registers ahead of time and then switch one channel or every channel to its new code in a single operation.

Top module: `dac_bank_ctrl`

## Requirements
- R1: Command 4'h0 loads `code_i` into the holding register of the addressed channel. Active codes do not change.
- R2: Command 4'h1 copies the addressed channel's holding register into its active register, and the result appears on `dac_code_o` one clock after the strobe.
- R3: Command 4'h2 writes `code_i` into the addressed channel's holding register and, in the same operation, copies every channel's holding register into its active register. The addressed channel receives the new code.
- R4: Command 4'h3 places `code_i` into both the holding and the active register of the addressed channel.
- R5: Every channel that an update (commands 4'h1, 4'h2, 4'h3) touches is enabled (`ch_en_o` bit = 1) after the operation.
- R6: Command 4'h4 clears the enable of the addressed channel. Command 4'h5 clears every enable and sets `ref_on_o` to 0, leaving `ref_int_sel_o` as it was.
- R7: Command 4'h6 sets `ref_int_sel_o`=1 and `ref_on_o`=1. Command 4'h7 sets both to 0.
- R8: Address values 0 up to NUM_CH-1 select that channel (channel i occupies bits [i*CODE_W +: CODE_W] of `dac_code_o` and bit i of `ch_en_o`). Address 4'hF selects every channel.
- R9: Command 4'hF, any command code not listed above, and any channel command (4'h0–4'h4) that carries an address which is neither a channel number nor 4'hF leave every output unchanged.
- R10: After reset, every active code equals zero-scale (MIDSCALE_RESET=0) or mid-scale, meaning only the MSB is set (MIDSCALE_RESET=1). Holding registers hold the same value, and all channels are enabled. `ref_int_sel_o` and `ref_on_o` both equal INT_REF_RESET.
- R11: `code_i` has no effect on commands that include no write (4'h1, 4'h4–4'h7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | One-cycle strobe: execute the presented command |
| cmd_i | input | 4 | Command code |
| addr_i | input | 4 | Channel address, 4'hF for all channels |
| code_i | input | CODE_W | Data code for write commands |
| dac_code_o | output | NUM_CH*CODE_W | Active codes, channel 0 in the low bits |
| ch_en_o | output | NUM_CH | Per-channel enable (1 = powered) |
| ref_int_sel_o | output | 1 | 1 = on-chip reference selected |
| ref_on_o | output | 1 | 1 = on-chip reference powered |

## Verification
The assertions check several rules on every clock. Any update leaves its channel enabled, and a power-down leaves it disabled. An active code moves only when an update is decoded. A write puts the strobed code into the holding register. Reserved or no-op strobes leave all outputs unchanged. The reference commands produce the select and power states they name. Other behaviour cannot be seen from a single cycle and only the bench's scenarios show it. These cases are: a value written into the holding register well before the update is the value that reaches the output, the write-one/update-all command gives the addressed channel its fresh code, broadcast applies to every channel, the data word is ignored on non-write commands, and the parameterised mid-scale and external-reference reset state is correct.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
   localparam int CMD_W  = 4;
   localparam int ADDR_W = 4;

   typedef enum logic [CMD_W-1:0] {
      OP_LOAD        = 4'h0,
      OP_COMMIT      = 4'h1,
      OP_LOAD_ALLCOM = 4'h2,
      OP_LOAD_COMMIT = 4'h3,
      OP_SLEEP_CH    = 4'h4,
      OP_SLEEP_ALL   = 4'h5,
      OP_REF_ONCHIP  = 4'h6,
      OP_REF_OFFCHIP = 4'h7,
      OP_IDLE        = 4'hF
   } op_e;

   localparam logic [ADDR_W-1:0] ADDR_BCAST = 4'hF;
endpackage

// File: rtl/dbc_decode.sv
module dbc_decode
   import dbc_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic              exec_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NUM_CH-1:0] wr_o,
   output logic [NUM_CH-1:0] upd_o,
   output logic [NUM_CH-1:0] pd_o,
   output logic              ref_int_go_o,
   output logic              ref_ext_go_o,
   output logic              chip_off_o
);
   logic [NUM_CH-1:0] hit;
   logic              addr_ok;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
      assign hit[i] = (addr_i == ADDR_BCAST) || (addr_i == ADDR_W'(i));
   end
   assign addr_ok = |hit;

   always_comb begin
      wr_o         = '0;
      upd_o        = '0;
      pd_o         = '0;
      ref_int_go_o = 1'b0;
      ref_ext_go_o = 1'b0;
      chip_off_o   = 1'b0;
      if (exec_i) begin
         case (cmd_i)
            OP_LOAD:        wr_o = hit;
            OP_COMMIT:      upd_o = hit;
            OP_LOAD_ALLCOM: begin
               wr_o  = hit;
               upd_o = addr_ok ? '1 : '0;
            end
            OP_LOAD_COMMIT: begin
               wr_o  = hit;
               upd_o = hit;
            end
            OP_SLEEP_CH:    pd_o = hit;
            OP_SLEEP_ALL: begin
               pd_o       = '1;
               chip_off_o = 1'b1;
            end
            OP_REF_ONCHIP:  ref_int_go_o = 1'b1;
            OP_REF_OFFCHIP: ref_ext_go_o = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dbc_channel.sv
module dbc_channel #(
   parameter int                 CODE_W   = 12,
   parameter logic [CODE_W-1:0]  RST_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              upd_i,
   input  logic              pd_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] dac_o,
   output logic              en_o
);
   logic [CODE_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= RST_CODE;
         dac_o  <= RST_CODE;
         en_o   <= 1'b1;
      end else begin
         if (wr_i) hold_q <= code_i;
         if (upd_i) begin
            dac_o <= wr_i ? code_i : hold_q;
            en_o  <= 1'b1;
         end else if (pd_i) begin
            en_o  <= 1'b0;
         end
      end
   end

   assert_upd_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> en_o);
   assert_pd_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_i && !upd_i) |=> !en_o);
   assert_code_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(dac_o));
   assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (hold_q == $past(code_i)));
   assert_wr_upd_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && upd_i) |=> (dac_o == $past(code_i)));
endmodule

// File: rtl/dbc_refctl.sv
module dbc_refctl #(
   parameter bit INT_REF_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_int_go_i,
   input  logic ref_ext_go_i,
   input  logic chip_off_i,
   output logic sel_int_o,
   output logic ref_on_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_int_o <= INT_REF_RESET;
         ref_on_o  <= INT_REF_RESET;
      end else if (ref_int_go_i) begin
         sel_int_o <= 1'b1;
         ref_on_o  <= 1'b1;
      end else if (ref_ext_go_i) begin
         sel_int_o <= 1'b0;
         ref_on_o  <= 1'b0;
      end else if (chip_off_i) begin
         ref_on_o  <= 1'b0;
      end
   end

   assert_ref_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_int_go_i |=> (sel_int_o && ref_on_o));
   assert_ref_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ext_go_i |=> (!sel_int_o && !ref_on_o));
   assert_chip_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chip_off_i |=> (!ref_on_o && $stable(sel_int_o)));
endmodule

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl
   import dbc_pkg::*;
#(
   parameter int NUM_CH         = 8,
   parameter int CODE_W         = 12,
   parameter bit MIDSCALE_RESET = 1'b0,
   parameter bit INT_REF_RESET  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     exec_i,
   input  logic [3:0]               cmd_i,
   input  logic [3:0]               addr_i,
   input  logic [CODE_W-1:0]        code_i,
   output logic [NUM_CH*CODE_W-1:0] dac_code_o,
   output logic [NUM_CH-1:0]        ch_en_o,
   output logic                     ref_int_sel_o,
   output logic                     ref_on_o
);
   localparam logic [CODE_W-1:0] RST_CODE =
      MIDSCALE_RESET ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

   if (NUM_CH < 1 || NUM_CH > 15) begin : g_bad_nch
      $error("NUM_CH must be 1..15 so that 4'hF stays the broadcast address");
   end
   if (CODE_W < 2 || CODE_W > 16) begin : g_bad_w
      $error("CODE_W must be 2..16");
   end

   logic [NUM_CH-1:0] wr, upd, pd;
   logic              ref_int_go, ref_ext_go, chip_off;

   dbc_decode #(.NUM_CH(NUM_CH)) u_dec (
      .exec_i      (exec_i),
      .cmd_i       (cmd_i),
      .addr_i      (addr_i),
      .wr_o        (wr),
      .upd_o       (upd),
      .pd_o        (pd),
      .ref_int_go_o(ref_int_go),
      .ref_ext_go_o(ref_ext_go),
      .chip_off_o  (chip_off)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dbc_channel #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_ch (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_i  (wr[i]),
         .upd_i (upd[i]),
         .pd_i  (pd[i]),
         .code_i(code_i),
         .dac_o (dac_code_o[i*CODE_W +: CODE_W]),
         .en_o  (ch_en_o[i])
      );
   end

   dbc_refctl #(.INT_REF_RESET(INT_REF_RESET)) u_ref (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_int_go_i(ref_int_go),
      .ref_ext_go_i(ref_ext_go),
      .chip_off_i  (chip_off),
      .sel_int_o   (ref_int_sel_o),
      .ref_on_o    (ref_on_o)
   );

   logic reserved_cmd;
   assign reserved_cmd = (cmd_i > 4'h7);

   assert_reserved_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && reserved_cmd) |=> ($stable(dac_code_o) && $stable(ch_en_o)
                                    && $stable(ref_int_sel_o) && $stable(ref_on_o)));
   assert_no_strobe_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> ($stable(dac_code_o) && $stable(ch_en_o) && $stable(ref_on_o)));
endmodule

// File: tb/test_dac_bank_ctrl.sv
module test_dac_bank_ctrl;
   localparam int NCH = 8;
   localparam int W   = 12;
   localparam bit MID = 1'b1;
   localparam bit IREF = 1'b0;
   localparam logic [W-1:0] RSTV = MID ? 12'h800 : 12'h000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic exec = 1'b0;
   logic [3:0] cmd = 4'hF, addr = 4'h0;
   logic [W-1:0] code = '0;
   logic [NCH*W-1:0] dac;
   logic [NCH-1:0] en;
   logic rsel, ron;

   always #2.5 clk = ~clk;

   dac_bank_ctrl #(.NUM_CH(NCH), .CODE_W(W), .MIDSCALE_RESET(MID),
                   .INT_REF_RESET(IREF)) i_dac_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .exec_i(exec), .cmd_i(cmd), .addr_i(addr),
      .code_i(code), .dac_code_o(dac), .ch_en_o(en),
      .ref_int_sel_o(rsel), .ref_on_o(ron));

   // behavioural reference model
   logic [W-1:0] m_hold [NCH];
   logic [W-1:0] m_act  [NCH];
   logic         m_en   [NCH];
   logic         m_sel, m_on;
   string        tag = "R10", m_tag = "R10";
   int           vectors = 0, errs = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_hold[i] = RSTV; m_act[i] = RSTV; m_en[i] = 1'b1;
         end
         m_sel = IREF; m_on = IREF; m_tag = "R10";
      end else if (exec) begin
         bit any;
         any = (addr == 4'hF) || (int'(addr) < NCH);
         m_tag = tag;
         for (int i = 0; i < NCH; i++) begin
            bit s;
            s = (addr == 4'hF) || (int'(addr) == i);
            case (cmd)
               4'h0: if (s) m_hold[i] = code;
               4'h1: if (s) begin m_act[i] = m_hold[i]; m_en[i] = 1'b1; end
               4'h2: begin
                  if (s) m_hold[i] = code;
                  if (any) begin m_act[i] = m_hold[i]; m_en[i] = 1'b1; end
               end
               4'h3: if (s) begin m_hold[i] = code; m_act[i] = code; m_en[i] = 1'b1; end
               4'h4: if (s) m_en[i] = 1'b0;
               4'h5: m_en[i] = 1'b0;
               default: ;
            endcase
         end
         case (cmd)
            4'h5: m_on = 1'b0;
            4'h6: begin m_sel = 1'b1; m_on = 1'b1; end
            4'h7: begin m_sel = 1'b0; m_on = 1'b0; end
            default: ;
         endcase
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         vectors++;
         for (int i = 0; i < NCH; i++) begin
            if (dac[i*W +: W] !== m_act[i]) begin
               errs++;
               $display("FAIL %s ch%0d code: actual %h expected %h", m_tag, i, dac[i*W +: W], m_act[i]);
            end
            if (en[i] !== m_en[i]) begin
               errs++;
               $display("FAIL %s ch%0d enable: actual %b expected %b", m_tag, i, en[i], m_en[i]);
            end
         end
         if (rsel !== m_sel || ron !== m_on) begin
            errs++;
            $display("FAIL %s ref sel/on: actual %b%b expected %b%b", m_tag, rsel, ron, m_sel, m_on);
         end
      end
   end

   task automatic op(input logic [3:0] c, input logic [3:0] a, input logic [W-1:0] d, input string t);
      @(negedge clk);
      tag = t; cmd = c; addr = a; code = d; exec = 1'b1;
      @(negedge clk);
      exec = 1'b0; code = W'($urandom); cmd = 4'(($urandom));
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);              // R10 reset state compared
      op(4'h0, 4'h2, 12'h123, "R1");          // R1 write only
      op(4'h0, 4'h5, 12'hABC, "R1");
      op(4'h1, 4'h2, 12'hFFF, "R11");         // R2 update, data ignored R11
      op(4'h4, 4'h5, 12'h000, "R6");          // R6 power down one
      op(4'h1, 4'h5, 12'h555, "R5");          // R5 update powers up
      op(4'h0, 4'h6, 12'h0F0, "R3");
      op(4'h2, 4'h0, 12'h456, "R3");          // R3 write one, update all
      op(4'h3, 4'h7, 12'h777, "R4");          // R4
      op(4'h0, 4'hF, 12'h321, "R8");          // R8 broadcast write
      op(4'h1, 4'h3, 12'h000, "R2");
      op(4'h4, 4'hF, 12'h000, "R8");
      op(4'h1, 4'hF, 12'h999, "R8");
      op(4'h8, 4'h0, 12'h111, "R9");          // R9 reserved command
      op(4'h0, 4'h8, 12'h222, "R9");          // reserved address
      op(4'h2, 4'h9, 12'h333, "R9");
      op(4'h1, 4'hF, 12'h000, "R9");          // proves holding regs untouched
      op(4'hF, 4'hF, 12'h444, "R9");
      op(4'h6, 4'h0, 12'hFFF, "R7");          // R7
      op(4'h7, 4'h3, 12'hFFF, "R7");
      op(4'h6, 4'h1, 12'h000, "R7");
      op(4'h5, 4'h2, 12'hAAA, "R6");          // R6 chip off
      op(4'h3, 4'h1, 12'h0AB, "R5");
      for (int k = 0; k < 60; k++)
         op(4'($urandom_range(0, 9)) == 4'h9 ? 4'hF : 4'($urandom_range(0, 8)),
            ($urandom_range(0, 5) == 0) ? 4'hF : 4'($urandom_range(0, 9)),
            W'($urandom), "R8");
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end
endmodule